// File: doc/BRIEF.md
# Two-Wire Bus Memory Slave Engine

This block is the protocol engine of a 4K x 8 byte memory that answers on a two-wire serial bus (clock line plus open-drain data line). It runs on a fast system clock and samples both bus lines through synchronisers. It finds START and STOP conditions, shifts bytes in, decodes the control byte against a fixed device code and three strap inputs, and loads a persistent 12-bit address pointer from two address bytes. It returns read data MSB first from a synchronous memory read port. The read can be a current-address, random or sequential read. Write data bytes go out on a valid/ready stream to a separate page-write unit, which owns the array, page wrapping and the timed write cycle.

The data line is driven only as an active-low enable (`sda_oe_o` = 1 pulls the line low). Every change of that enable is launched a fixed number of system clocks after the synchronised clock line falls, so the block can never create a START or STOP by accident. While `busy_i` is high, which means an internal write cycle is running, the block acknowledges nothing. A master can therefore poll for completion with a bare control byte.

Write stream rules: `wr_valid_o` rises with an accepted data byte and its address. It stays high, with `wr_data_o` and `wr_addr_o` frozen, until `wr_ready_i` is seen high on a clock edge. If another data byte completes while the previous one is still waiting, the block does not acknowledge it. It drops that byte and ignores the bus until the next START or STOP. `wr_commit_o` pulses for one clock when a transaction that passed at least one data byte ends.

Top module: `twb_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is START, and a rising data line while the clock line is high is STOP. STOP in any state releases the data line and returns to idle. START in any state abandons the current byte and expects a control byte.
- R2: The control byte is received MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `sel_i[2:0]` (bit 3 against `sel_i[2]`), and bit 0 selects read (1) or write (0). On a match the block pulls the data line low for the ninth clock. On a mismatch it never drives the line until the next START.
- R3: After a write control byte, the next two bytes are the address high byte then the low byte. Both are acknowledged. Bits 3:0 of the high byte and all of the low byte load the pointer, and bits 7:4 of the high byte are ignored.
- R4: Each acknowledged data byte appears on the write stream with `wr_addr_o` equal to the pointer, and the pointer then advances by one. `wr_commit_o` pulses once when START or STOP ends a transaction that passed at least one data byte.
- R5: A random read is made of three parts: a write control byte, two address bytes, then a repeated START and a read control byte. It returns the byte at the loaded address, fetched through a single-cycle `mem_rd_en_o` pulse.
- R6: A current-address read returns the byte at the pointer, which is one past the last byte read or written.
- R7: A master acknowledge (data line low in the ninth clock) after a read byte fetches and sends the next byte. The pointer wraps from 0xFFF to 0x000.
- R8: A master non-acknowledge after a read byte makes the block leave the data line released until the next START or STOP.
- R9: While `busy_i` is high at the end of a byte, that byte is not acknowledged. A control byte that is not acknowledged leaves the block silent until the next START.
- R10: While `wr_valid_o` is high and `wr_ready_i` is low, the write stream outputs hold. A data byte that completes in that state is not acknowledged and does not advance the pointer.
- R11: `sda_oe_o` changes only while the clock line is low, `OUT_DLY` system clocks after the synchronised falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sel_i | input | 3 | Strap select bits matched against control byte bits 3:1 |
| busy_i | input | 1 | Internal write cycle in progress; suppresses acknowledges |
| mem_rd_en_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | ADDR_W | Memory read address (the pointer) |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| wr_valid_o | output | 1 | Write byte available |
| wr_ready_i | input | 1 | Page-write unit accepts the byte |
| wr_addr_o | output | ADDR_W | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | One-cycle pulse ending a transaction that passed data |

## Verification
The bench builds the block with its defaults: a 12-bit pointer, two synchroniser stages and a four-clock output delay. The 12-bit width puts the 0xFFF to 0x000 wrap within reach of a short sequential read. The four-clock delay, set against a bench quarter-bit of eight clocks, lets a monitor show that the data line never moves while the clock line is high. Stalling the write stream exposes the non-acknowledged second byte. Polling under `busy_i` and mismatched control bytes show the silent paths.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADRH,
    ST_ADRL,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } twb_state_e;

  localparam logic [3:0] TWB_DEV_CODE = 4'b1010;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_i;
          sda_p[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
      end
    end
  end

  assign scl_o = scl_p[STAGES-1];
  assign sda_o = sda_p[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twb_addr_ptr.sv
module twb_addr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + AW'(1);
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && ptr_o == '1) |=> (ptr_o == '0)); // R7
endmodule

// File: rtl/twb_oe_launch.sv
module twb_oe_launch #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic val_i,
  input  logic clr_i,
  output logic oe_o
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt  <= '0;
      pend <= 1'b0;
      oe_o <= 1'b0;
    end else if (arm_i) begin
      cnt  <= CW'(DLY);
      pend <= val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) oe_o <= pend;
    end
  end

  AST_OE_NOT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !clr_i) |=> $stable(oe_o)); // R11
endmodule

// File: rtl/twb_mem_slave.sv
module twb_mem_slave
  import twb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_DLY     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        sel_i,
  input  logic              busy_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  twb_state_e    st;
  logic [3:0]    bitcnt;
  logic [6:0]    shreg;
  logic [7:0]    byte_in, tx;
  logic [HI_W-1:0] adr_hi;
  logic          ack_pend, ctrl_rd, rd_pend, wr_seen;
  logic          active, byte_done, ctrl_ok, wr_take;
  logic          ptr_load, ptr_inc, oe_val;
  logic [ADDR_W-1:0] ptr;

  twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twb_addr_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
    .load_val_i({adr_hi, byte_in}), .inc_i(ptr_inc), .ptr_o(ptr)
  );

  always_comb begin
    byte_in   = {shreg, sda_s};
    active    = (st != ST_IDLE) && (st != ST_IGNORE);
    byte_done = scl_rise && active && (bitcnt == 4'd7);
    ctrl_ok   = (byte_in[7:4] == TWB_DEV_CODE) && (byte_in[3:1] == sel_i) && !busy_i;
    wr_take   = !busy_i && (!wr_valid_o || wr_ready_i);
    ptr_load  = byte_done && (st == ST_ADRL) && !busy_i;
    ptr_inc   = byte_done && (((st == ST_WDATA) && wr_take) || (st == ST_RDATA));
    oe_val    = ((bitcnt == 4'd8) && ack_pend) ||
                ((st == ST_RDATA) && (bitcnt < 4'd8) && !tx[~bitcnt[2:0]]);
  end

  twb_oe_launch #(.DLY(OUT_DLY)) u_oe (
    .clk(clk), .rst_n(rst_n), .arm_i(scl_fall), .val_i(oe_val),
    .clr_i(start_c | stop_c), .oe_o(sda_oe_o)
  );

  assign mem_addr_o = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      adr_hi      <= '0;
      tx          <= '0;
      ack_pend    <= 1'b0;
      ctrl_rd     <= 1'b0;
      rd_pend     <= 1'b0;
      wr_seen     <= 1'b0;
      mem_rd_en_o <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      mem_rd_en_o <= 1'b0;
      wr_commit_o <= 1'b0;
      rd_pend     <= mem_rd_en_o;
      if (rd_pend) tx <= mem_rd_data_i;
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;

      if (start_c || stop_c) begin
        st          <= start_c ? ST_CTRL : ST_IDLE;
        bitcnt      <= '0;
        ack_pend    <= 1'b0;
        wr_commit_o <= wr_seen;
        wr_seen     <= 1'b0;
      end else if (scl_rise && active) begin
        if (bitcnt != 4'd8) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            unique case (st)
              ST_CTRL: begin
                ack_pend <= ctrl_ok;
                ctrl_rd  <= byte_in[0];
                if (ctrl_ok && byte_in[0]) mem_rd_en_o <= 1'b1;
              end
              ST_ADRH: begin
                ack_pend <= !busy_i;
                adr_hi   <= byte_in[HI_W-1:0];
              end
              ST_ADRL: ack_pend <= !busy_i;
              ST_WDATA: begin
                ack_pend <= wr_take;
                if (wr_take) begin
                  wr_valid_o <= 1'b1;
                  wr_data_o  <= byte_in;
                  wr_addr_o  <= ptr;
                  wr_seen    <= 1'b1;
                end
              end
              default: ack_pend <= 1'b0;
            endcase
          end
        end else begin
          bitcnt   <= '0;
          ack_pend <= 1'b0;
          unique case (st)
            ST_CTRL:  st <= !ack_pend ? ST_IGNORE : (ctrl_rd ? ST_RDATA : ST_ADRH);
            ST_ADRH:  st <= ack_pend ? ST_ADRL : ST_IGNORE;
            ST_ADRL:  st <= ack_pend ? ST_WDATA : ST_IGNORE;
            ST_WDATA: st <= ack_pend ? ST_WDATA : ST_IGNORE;
            ST_RDATA: begin
              if (!sda_s) mem_rd_en_o <= 1'b1;
              else        st <= ST_IGNORE;
            end
            default:  st <= ST_IGNORE;
          endcase
        end
      end
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == ST_IDLE && !sda_oe_o)); // R1
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pend) |-> !$past(busy_i)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o))); // R10
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !mem_rd_en_o); // R5
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o)); // R11
endmodule

// File: tb/twb_mem_slave_tb_top.sv
module twb_mem_slave_tb_top;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW_WR = 8'hAA;
  localparam logic [7:0] CW_RD = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, msda = 1'b1;
  logic busy = 1'b0, wr_ready = 1'b1;
  logic sda_oe, mem_rd_en, wr_valid, wr_commit;
  logic [11:0] mem_addr, wr_addr;
  logic [7:0] mem_rd_data = 8'h00, wr_data;
  logic sda_line;
  int vectors = 0, fails = 0, commits = 0, edge_viol = 0;
  bit done = 0;
  logic [7:0] bmem [int];

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  twb_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel_i(SEL), .busy_i(busy), .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr),
    .mem_rd_data_i(mem_rd_data), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] rd(input logic [11:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return a[7:0] ^ {a[11:8], 4'hC};
  endfunction

  logic oe_d = 1'b0, scl_d = 1'b1;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= rd(mem_addr);
    if (wr_valid && wr_ready) bmem[int'(wr_addr)] = wr_data;
    if (wr_commit) commits++;
    if (rst_n && sda_oe !== oe_d && scl_m && scl_d) edge_viol++;
    oe_d  <= sda_oe;
    scl_d <= scl_m;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); msda = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); msda = 1'b1; wt(Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    msda = b; wt(Q); scl_m = 1'b1; wt(Q/2); r = sda_line; wt(Q/2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~mack, r);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bus_start(); send_byte(CW_WR, a); chk({req, " ctrl ack"}, a, 1);
    send_byte(hi, a); chk({req, " addr hi ack"}, a, 1);
    send_byte(lo, a); chk({req, " addr lo ack"}, a, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R4 reset wr_valid", wr_valid, 0);
  endtask

  task automatic t_write();
    logic a;
    set_addr(8'hF1, 8'h23, "R3");
    send_byte(8'h11, a); chk("R4 data0 ack", a, 1);
    send_byte(8'h22, a); chk("R4 data1 ack", a, 1);
    send_byte(8'h33, a); chk("R4 data2 ack", a, 1);
    bus_stop(); wt(4);
    chk("R3 top nibble ignored", bmem.exists(32'h123), 1);
    chk("R4 byte at 0x124", rd(12'h124), 8'h22);
    chk("R4 byte at 0x125", rd(12'h125), 8'h33);
    chk("R4 one commit", commits, 1);
  endtask

  task automatic t_cur_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(CW_RD, a); chk("R2 read ctrl ack", a, 1);
    recv_byte(1'b0, d); chk("R6 current address", d, rd(12'h126));
    bus_stop();
  endtask

  task automatic t_rand_read();
    logic a, r; logic [7:0] d;
    set_addr(8'h01, 8'h24, "R5");
    bus_start(); send_byte(CW_RD, a); chk("R5 read ctrl ack", a, 1);
    recv_byte(1'b1, d); chk("R5 random byte", d, 8'h22);
    recv_byte(1'b1, d); chk("R7 sequential byte", d, 8'h33);
    recv_byte(1'b0, d); chk("R7 third byte", d, rd(12'h126));
    bit_io(1'b1, r); chk("R8 released after nack", r, 1);
    bus_stop();
    chk("R4 no commit without data", commits, 1);
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    set_addr(8'h0F, 8'hFE, "R7");
    bus_start(); send_byte(CW_RD, a); chk("R7 read ctrl ack", a, 1);
    recv_byte(1'b1, d); chk("R7 byte 0xFFE", d, rd(12'hFFE));
    recv_byte(1'b1, d); chk("R7 byte 0xFFF", d, rd(12'hFFF));
    recv_byte(1'b0, d); chk("R7 wrap to 0x000", d, rd(12'h000));
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hA2, a); chk("R2 wrong select no ack", a, 0);
    recv_byte(1'b0, d); chk("R2 silent after mismatch", d, 8'hFF);
    bus_start(); send_byte(8'hBA, a); chk("R2 wrong code no ack", a, 0);
    bus_stop();
  endtask

  task automatic t_busy();
    logic a; logic [7:0] d;
    busy = 1'b1;
    bus_start(); send_byte(CW_WR, a); chk("R9 busy no ack", a, 0);
    recv_byte(1'b0, d); chk("R9 silent while busy", d, 8'hFF);
    bus_stop();
    busy = 1'b0;
    bus_start(); send_byte(CW_WR, a); chk("R9 ack after busy", a, 1);
    bus_stop();
  endtask

  task automatic t_stop_abort();
    logic a, r; logic [7:0] d;
    bus_start(); send_byte(CW_WR, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, r);
    bus_stop(); wt(2);
    chk("R1 released after stop", sda_oe, 0);
    bus_start(); send_byte(CW_RD, a); chk("R1 ctrl after abort", a, 1);
    recv_byte(1'b0, d); chk("R1 pointer kept", d, rd(12'h001));
    bus_stop();
  endtask

  task automatic t_backpressure();
    logic a; logic [7:0] d;
    wr_ready = 1'b0;
    set_addr(8'h03, 8'h00, "R10");
    send_byte(8'h5A, a); chk("R10 first byte ack", a, 1);
    send_byte(8'h6B, a); chk("R10 second byte nack", a, 0);
    chk("R10 valid held", wr_valid, 1);
    chk("R10 data held", wr_data, 8'h5A);
    chk("R10 addr held", wr_addr, 12'h300);
    wr_ready = 1'b1; wt(2);
    bus_stop(); wt(4);
    chk("R10 byte delivered", rd(12'h300), 8'h5A);
    chk("R4 second commit", commits, 2);
    bus_start(); send_byte(CW_RD, a);
    recv_byte(1'b0, d); chk("R10 pointer not advanced", d, rd(12'h301));
    bus_stop();
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_write();
    t_cur_read();
    t_rand_read();
    t_wrap();
    t_mismatch();
    t_busy();
    t_stop_abort();
    t_backpressure();
    chk("R11 no change while clock high", edge_viol, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule